// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block holds the register set that system software uses for basic power management. A 64-byte I/O window contains an event status word, an event enable word, a control word and a free-running power-management timer. The timer advances on a single-cycle tick-enable input that carries the 3.579545 MHz timebase into the system clock domain. Each time the timer reaches the next multiple of half its range, an overflow status flag is raised. Software clears that flag by writing a one to it.

A level interrupt output is raised while an enabled status bit is set. A separate byte-wide command port turns the system-interrupt enable bit of the control word on or off. When software writes a sleep command of type zero to the control word, the block emits a one-cycle soft power-off request. The sleep-enable bit itself is never kept.

Top module: `pm_event_regs`

## Requirements
- R1: After reset, the timer, the overflow flag, the enable word, the control word, `rdata`, `irq` and `poweroff_req` are all zero, and the first overflow point is 2^(TMR_W-1).
- R2: The timer grows by one on each cycle with `tick` high, holds on the other cycles, and wraps modulo 2^TMR_W. A read at offset 0x08 returns the count in the low TMR_W bits, with all higher bits zero.
- R3: Status bit 0 (overflow flag) is set by the tick that brings the timer onto the current overflow point. It stays set until it is cleared.
- R4: A write to offset 0x00 clears status bit 0 when `wdata[0]` is 1 and leaves it alone when `wdata[0]` is 0. Clearing a flag that was set moves the overflow point to the next multiple of 2^(TMR_W-1) above the current count, modulo 2^TMR_W. If a set and a clear fall in the same cycle, the set wins. A status read returns the flag in bit 0 and zero in all other bits.
- R5: A write to offset 0x02 replaces the whole 16-bit enable word with `wdata[15:0]`. A read returns the stored word.
- R6: `irq` is the OR, over bits 0, 5, 8 and 10, of status AND enable. Only status bit 0 is ever set, so enable bits 5, 8 and 10 alone never raise `irq`.
- R7: A write to offset 0x04 stores `wdata[15:0]` with bit 13 forced to zero. A read returns the stored word, so bit 13 always reads 0.
- R8: `poweroff_req` is high for exactly the one cycle after a control write that has bit 13 set and bits 11:10 equal to 00. A sleep type of 01, 10 or 11 gives no pulse.
- R9: A `cmd_wr` with `cmd_data` 0xF1 sets control bit 0, and one with 0xF0 clears it. Any other value leaves the control word unchanged. When a control write and a command fall in the same cycle, the command decides bit 0.
- R10: Only `addr[5:0]` is decoded, so the window repeats every 64 bytes. Reads at offsets other than 0x00, 0x02, 0x04 and 0x08 return zero. Writes to those other offsets, and to 0x08, change nothing.
- R11: `rdata` is registered. It takes the addressed value on the clock edge where `rd_en` is high and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle timer advance enable |
| addr | input | ADDR_W | Register address (low 6 bits decoded) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cmd_wr | input | 1 | Command-port byte write strobe |
| cmd_data | input | 8 | Command-port byte |
| irq | output | 1 | Level interrupt from enabled status bits |
| poweroff_req | output | 1 | One-cycle soft power-off request |

## Verification
The embedded properties assume that every input is a known value on each clock edge after reset, and that `tick`, `wr_en`, `rd_en` and `cmd_wr` are plain per-cycle strobes with no protocol of their own. They also assume that TMR_W is below 32, so that the zero-extension check for timer reads has upper bits to test. The stimulus changes its inputs only on falling edges and never leaves an input undriven. It uses a timer narrowed to 8 bits, so that overflow points and the counter wrap come around many times within a short run. Random cycles combine ticks with reads, writes, command bytes, aliased addresses and unmapped offsets. This lets clears, sets and command overrides fall in the same cycle.

// File: rtl/pm_event_regs.sv
module pm_event_regs #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_data,
  output logic              irq,
  output logic              poweroff_req
);
  localparam logic [5:0]  OFF_STS  = 6'h00;
  localparam logic [5:0]  OFF_EN   = 6'h02;
  localparam logic [5:0]  OFF_CTL  = 6'h04;
  localparam logic [5:0]  OFF_TMR  = 6'h08;
  localparam logic [15:0] IRQ_MSK  = 16'h0521;
  localparam int          SLP_BIT  = 13;
  localparam logic [7:0]  CMD_ON   = 8'hF1;
  localparam logic [7:0]  CMD_OFF  = 8'hF0;

  logic [5:0]       off;
  logic [TMR_W-1:0] cnt, cnt_inc;
  logic             tgt_hi, ovf, reach, clr;
  logic [15:0]      en, ctl, sts;
  logic             wr_sts, wr_en_reg, wr_ctl;

  assign off       = addr[5:0];
  assign wr_sts    = wr_en && off == OFF_STS;
  assign wr_en_reg = wr_en && off == OFF_EN;
  assign wr_ctl    = wr_en && off == OFF_CTL;
  assign cnt_inc   = cnt + 1'b1;
  assign reach     = tick && cnt_inc == {tgt_hi, {(TMR_W-1){1'b0}}};
  assign clr       = wr_sts && wdata[0];
  assign sts       = {15'b0, ovf};
  assign irq       = |(sts & en & IRQ_MSK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      tgt_hi       <= 1'b1;
      ovf          <= 1'b0;
      en           <= '0;
      ctl          <= '0;
      poweroff_req <= 1'b0;
    end else begin
      if (tick) cnt <= cnt_inc;
      if (clr && ovf) tgt_hi <= ~cnt[TMR_W-1];
      ovf <= (ovf && !clr) || reach;
      if (wr_en_reg) en <= wdata[15:0];
      if (wr_ctl) ctl <= wdata[15:0] & ~(16'b1 << SLP_BIT);
      if (cmd_wr && cmd_data == CMD_ON)  ctl[0] <= 1'b1;
      if (cmd_wr && cmd_data == CMD_OFF) ctl[0] <= 1'b0;
      poweroff_req <= wr_ctl && wdata[SLP_BIT] && wdata[11:10] == 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (off)
        OFF_STS: rdata <= {16'b0, sts};
        OFF_EN:  rdata <= {16'b0, en};
        OFF_CTL: rdata <= {16'b0, ctl};
        OFF_TMR: rdata <= {{(32-TMR_W){1'b0}}, cnt};
        default: rdata <= '0;
      endcase
    end
  end

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == $past(cnt)); // R2
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt_inc)); // R2
  AST_TMR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && off == OFF_TMR) |-> rdata[31:TMR_W] == '0); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !reach |=> !ovf); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf && en[0]); // R6
  AST_CTL_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && off == OFF_CTL) |-> !rdata[SLP_BIT]); // R7
  AST_POWEROFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    poweroff_req |-> $past(wr_en && addr[5:0] == OFF_CTL && wdata[SLP_BIT] && wdata[11:10] == 2'b00)); // R8
  AST_CMD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == CMD_ON |=> ctl[0]); // R9
  AST_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == CMD_OFF |=> !ctl[0]); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && off != OFF_STS && off != OFF_EN && off != OFF_CTL && off != OFF_TMR) |-> rdata == '0); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
endmodule

// File: tb/pm_event_regs_test.sv
module pm_event_regs_test;
  localparam int TW   = 8;
  localparam int FULL = 1 << TW;
  localparam int HALF = 1 << (TW - 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cmd_wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  cmd_data = '0;
  logic [31:0] rdata;
  logic irq, poweroff_req;

  int nchk = 0, nfail = 0;
  int m_cnt, m_tgt;
  logic m_flag, m_po;
  logic [15:0] m_en, m_ctl;
  logic [31:0] m_rd;
  string rd_tag;

  always #4 clk = ~clk;

  pm_event_regs #(.ADDR_W(16), .TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cmd_wr(cmd_wr),
    .cmd_data(cmd_data), .irq(irq), .poweroff_req(poweroff_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] read_model(input logic [5:0] o);
    case (o)
      6'h00: return {31'b0, m_flag};
      6'h02: return {16'b0, m_en};
      6'h04: return {16'b0, m_ctl};
      6'h08: return 32'(m_cnt);
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] o);
    case (o)
      6'h00: return "R3/R4 status read";
      6'h02: return "R5 enable read";
      6'h04: return "R7/R9 control read";
      6'h08: return "R2 timer read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  task automatic cyc(input logic wr, input logic rd, input logic [15:0] a, input logic [31:0] wd,
                     input logic cw, input logic [7:0] cd, input logic tk);
    logic [5:0] o;
    logic reach, clr;
    wr_en = wr; rd_en = rd; addr = a; wdata = wd; cmd_wr = cw; cmd_data = cd; tick = tk;
    o = a[5:0];
    if (rd) begin m_rd = read_model(o); rd_tag = tag_of(o); end
    else rd_tag = "R11 rdata hold";
    reach = tk && ((m_cnt + 1) % FULL) == m_tgt;
    clr = wr && o == 6'h00 && wd[0];
    if (clr && m_flag) m_tgt = (((m_cnt + HALF) / HALF) * HALF) % FULL;
    m_flag = (m_flag && !clr) || reach;
    if (tk) m_cnt = (m_cnt + 1) % FULL;
    if (wr && o == 6'h02) m_en = wd[15:0];
    if (wr && o == 6'h04) m_ctl = wd[15:0] & 16'hDFFF;
    m_po = wr && o == 6'h04 && wd[13] && wd[11:10] == 2'b00;
    if (cw && cd == 8'hF1) m_ctl[0] = 1'b1;
    if (cw && cd == 8'hF0) m_ctl[0] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; cmd_wr = 0; tick = 0;
    chk(rd_tag, rdata, m_rd);
    chk("R6 irq", {31'b0, irq}, {31'b0, |({15'b0, m_flag} & m_en & 16'h0521)});
    chk("R8 poweroff", {31'b0, poweroff_req}, {31'b0, m_po});
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
  task automatic rd(input logic [15:0] a); cyc(0, 1, a, 0, 0, 0, 0); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1); endtask
  task automatic cmd(input logic [7:0] c); cyc(0, 0, 0, 0, 1, c, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    m_cnt = 0; m_tgt = HALF; m_flag = 0; m_po = 0; m_en = 0; m_ctl = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata reset", rdata, 0);
    chk("R1 irq reset", {31'b0, irq}, 0);
    chk("R1 poweroff reset", {31'b0, poweroff_req}, 0);
    rd(16'h0000); rd(16'h0002); rd(16'h0004); rd(16'h0008);
    // R3 first overflow point at HALF
    ticks(HALF - 1); rd(16'h0000);
    chk("R3 flag before point", rdata, 0);
    ticks(1); rd(16'h0000);
    chk("R3 flag at point", rdata, 1);
    rd(16'h0008);
    chk("R2 count at point", rdata, HALF);
    wr(16'h0002, 32'h0000_0001);
    chk("R6 irq with enable", {31'b0, irq}, 1);
    wr(16'h0000, 32'hFFFF_FFFE); rd(16'h0000);
    chk("R4 write zero keeps flag", rdata, 1);
    wr(16'h0000, 32'h1); rd(16'h0000);
    chk("R4 clear flag", rdata, 0);
    // R2 wrap: next point is 0
    ticks(HALF - 1); rd(16'h0000);
    chk("R4 no early flag", rdata, 0);
    ticks(1); rd(16'h0008);
    chk("R2 wrap to zero", rdata, 0);
    rd(16'h0000);
    chk("R3 flag at wrap", rdata, 1);
    wr(16'h0002, 32'h0000_0520);
    chk("R6 other enables no irq", {31'b0, irq}, 0);
    // R7 R8
    wr(16'h0004, 32'h0000_FFFF); rd(16'h0004);
    chk("R7 bit13 dropped", rdata, 32'h0000_DFFF);
    wr(16'h0004, 32'h0000_2000);
    chk("R8 type0 pulse", {31'b0, poweroff_req}, 1);
    wr(16'h0004, 32'h0000_2400);
    chk("R8 type1 no pulse", {31'b0, poweroff_req}, 0);
    // R9
    cmd(8'hF1); rd(16'h0004);
    chk("R9 enable cmd", rdata, 32'h0000_0401);
    cmd(8'h55); rd(16'h0004);
    chk("R9 other cmd ignored", rdata, 32'h0000_0401);
    cmd(8'hF0); rd(16'h0004);
    chk("R9 disable cmd", rdata, 32'h0000_0400);
    // R10 aliasing and unmapped
    wr(16'h1242, 32'h0000_0001); rd(16'h0002);
    chk("R10 alias write", rdata, 1);
    wr(16'h0006, 32'hFFFF_FFFF); wr(16'h0008, 32'h0); rd(16'h0006);
    chk("R10 unmapped read", rdata, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] a;
      logic [31:0] d;
      logic [7:0] c;
      int k = $urandom % 8;
      a = 16'($urandom);
      case (k)
        0: a[5:0] = 6'h00;
        1: a[5:0] = 6'h02;
        2: a[5:0] = 6'h04;
        3: a[5:0] = 6'h08;
        default: ;
      endcase
      d = $urandom;
      k = $urandom % 4;
      c = (k == 0) ? 8'hF0 : (k == 1) ? 8'hF1 : 8'($urandom);
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, a, d, ($urandom % 4) == 0, c, ($urandom % 4) != 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule